// File: doc/BRIEF.md
# Addressable Latch System Control Port

This block is a one-byte system control register on an 8-bit I/O port. It behaves like an eight-bit addressable latch. Each write changes exactly one control bit. The low three bits of the written byte name the bit, and data bit 3 carries the new value in inverted form. A read returns the whole latched status byte.

Five of the eight latch positions are implemented. Each drives a system control line:

- the auxiliary PROM enable
- the bus override, which keeps other bus masters off the bus
- the startup ROM mapping at the bottom of memory
- the boot ROM select
- the processor interrupt enable

The remaining positions are not built and always read as zero.

The block contains the port decode (one chip select with read and write strobes), the latch bank, a synchronous active-low reset and the status readback. Memory remapping, bus arbitration and interrupt handling sit outside it and only consume its control lines.

Top module: `sysctl_latch_port`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the status byte becomes 0x00 and every control output goes low.
- R2: A write takes effect at the rising edge where `cs` and `wr_stb` are both high. The addressed bit takes the inverse of `din[3]`: `din[3]`=0 sets it to 1, and `din[3]`=1 clears it to 0.
- R3: A write changes at most one status bit, the one addressed by `din[2:0]`.
- R4: Address 0 maps to status bit 0 (`aux_prom_en`), address 1 to bit 1 (`bus_override`), address 2 to bit 2 (`startup_rom_sel`), address 4 to bit 4 (`boot_rom_sel`) and address 5 to bit 5 (`irq_en`).
- R5: Writes to addresses 3, 6 and 7 leave the status byte unchanged. Status bits 3, 6 and 7 always read as 0.
- R6: While `cs` and `rd_stb` are high, `dout` shows the current status byte combinationally; otherwise `dout` is 0x00. Reads never change the status byte.
- R7: With `cs` low or `wr_stb` low, nothing is written, whatever `din` holds.
- R8: When a read and a write fall in the same cycle, `dout` shows the byte as it was before that cycle's write, and the write still takes effect at the edge.
- R9: `din[7:4]` has no effect on a write.
- R10: Each control output always equals its status bit as read through `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Port chip select |
| wr_stb | input | 1 | Write strobe, qualified by `cs` |
| rd_stb | input | 1 | Read strobe, qualified by `cs` |
| din | input | 8 | Write byte: [2:0] bit address, [3] inverted value |
| dout | output | 8 | Status byte during a read, else 0x00 |
| aux_prom_en | output | 1 | Auxiliary PROM enable (status bit 0) |
| bus_override | output | 1 | Bus override (status bit 1) |
| startup_rom_sel | output | 1 | Startup ROM mapping (status bit 2) |
| boot_rom_sel | output | 1 | Boot ROM select (status bit 4) |
| irq_en | output | 1 | Processor interrupt enable (status bit 5) |

## Verification
A read and a write can be strobed in the same cycle, and the read must not see the byte that the write is about to latch. The bench provokes this with `cs`, `rd_stb` and `wr_stb` high together and a write that clears a bit that is currently set. It samples `dout` before the edge and expects the old byte. After the edge, the next read must show the changed bit. The per-clock reference model compares `dout` and all five control lines every cycle, so a design that forwards the incoming write to the read path, or that drops the write while a read is active, is caught in that cycle.

// File: rtl/sysctl_pkg.sv
// Package: shared widths, bit positions and the decoded write request type
// for the addressable latch control port.
package sysctl_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int VAL_POS = 3;

    // status bit positions; a write to address N updates bit N
    localparam int POS_AUX    = 0;
    localparam int POS_OVRD   = 1;
    localparam int POS_START  = 2;
    localparam int POS_BOOT   = 4;
    localparam int POS_IRQ    = 5;

    // mask of positions that are built; the others read as zero
    localparam logic [DATA_W-1:0] IMPL_MASK =
        (DATA_W'(1) << POS_AUX)  | (DATA_W'(1) << POS_OVRD) |
        (DATA_W'(1) << POS_START) | (DATA_W'(1) << POS_BOOT) |
        (DATA_W'(1) << POS_IRQ);

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic             val;
    } wr_req_t;
endpackage

// File: rtl/sysctl_port_decode.sv
// Port decode: qualifies the strobes with chip select and splits the
// written byte into a bit address and an (inverted) latch value.
// Assumes strobes are synchronous to clk; no registering here.
module sysctl_port_decode
    import sysctl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SEL_W,
    parameter int VP = VAL_POS
) (
    input  logic          cs,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic [VP:0]   din_lo,
    output wr_req_t       wr_req,
    output logic          rd_en
);
    // form the write request and read enable
    always_comb begin
        wr_req.en  = cs & wr_stb;
        wr_req.sel = din_lo[SW-1:0];
        wr_req.val = ~din_lo[VP];
        rd_en      = cs & rd_stb;
    end
endmodule

// File: rtl/sysctl_latch_bank.sv
// Latch bank: one flop per implemented position, updated only when the
// write request addresses it. Unbuilt positions are tied to zero.
// Assumes a synchronous active-low reset.
module sysctl_latch_bank
    import sysctl_pkg::*;
#(
    parameter int                DW   = DATA_W,
    parameter int                SW   = SEL_W,
    parameter logic [DW-1:0]     MASK = IMPL_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_req_t       wr_req,
    output logic [DW-1:0] stat_q
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            logic hit;
            // decode whether this cell is addressed
            always_comb hit = wr_req.en && (wr_req.sel == SW'(i));
            // latch the value into the addressed cell
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_q[i] <= 1'b0;
                else if (hit)
                    stat_q[i] <= wr_req.val;
            end
        end else begin : g_none
            assign stat_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sysctl_readback.sv
// Readback: presents the status byte on the data bus during a qualified
// read, zero otherwise. Purely combinational; reads have no side effect.
module sysctl_readback
    import sysctl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          rd_en,
    input  logic [DW-1:0] stat,
    output logic [DW-1:0] dout
);
    // gate the status onto the bus
    always_comb dout = rd_en ? stat : '0;
endmodule

// File: rtl/sysctl_latch_port.sv
// Top: addressable latch system control port. Joins decode, latch bank
// and readback and fans the status bits out to the control lines.
// Assumes a single clock and synchronous active-low reset.
module sysctl_latch_port
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              aux_prom_en,
    output logic              bus_override,
    output logic              startup_rom_sel,
    output logic              boot_rom_sel,
    output logic              irq_en
);
    wr_req_t           wr_req;
    logic              rd_en;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] din_used;

    // upper data bits carry no meaning; fold them away explicitly
    always_comb din_used = din & DATA_W'((1 << (VAL_POS + 1)) - 1);

    sysctl_port_decode u_dec (
        .cs     (cs),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .din_lo (din_used[VAL_POS:0]),
        .wr_req (wr_req),
        .rd_en  (rd_en)
    );

    sysctl_latch_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .stat_q (stat_q)
    );

    sysctl_readback u_rb (
        .rd_en (rd_en),
        .stat  (stat_q),
        .dout  (dout)
    );

    // drive control lines straight from their status flops
    always_comb begin
        aux_prom_en     = stat_q[POS_AUX];
        bus_override    = stat_q[POS_OVRD];
        startup_rom_sel = stat_q[POS_START];
        boot_rom_sel    = stat_q[POS_BOOT];
        irq_en          = stat_q[POS_IRQ];
    end
endmodule

// File: rtl/sysctl_latch_port_chk.sv
// Checker for the control port, bound to the top module.
module sysctl_latch_port_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic [DATA_W-1:0] stat_q,
    input logic              irq_en
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '0));

    // R5
    unbuilt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~IMPL_MASK) == '0);

    // R7
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr_stb) |=> $stable(stat_q));

    // R3
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_stb) |=> ($countones(stat_q ^ $past(stat_q)) <= 1));

    // R2
    irq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_stb && din[2:0] == 3'd5) |=> (irq_en == !$past(din[3])));

    // R6
    read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_stb) |-> (dout == stat_q));
endmodule

bind sysctl_latch_port sysctl_latch_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .din    (din),
    .dout   (dout),
    .stat_q (stat_q),
    .irq_en (irq_en)
);

// File: tb/sim_sysctl_latch_port.sv
`timescale 1ns/1ps
module sim_sysctl_latch_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       aux_prom_en, bus_override, startup_rom_sel, boot_rom_sel, irq_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit model_live = 1'b0;
    logic [7:0] model = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    sysctl_latch_port u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .din(din), .dout(dout), .aux_prom_en(aux_prom_en),
        .bus_override(bus_override), .startup_rom_sel(startup_rom_sel),
        .boot_rom_sel(boot_rom_sel), .irq_en(irq_en)
    );

    // behavioural reference: a byte with a list of writable positions
    always @(posedge clk) begin
        int a;
        if (!rst_n) model <= 8'h00;
        else if (cs && wr_stb) begin
            a = int'(din[2:0]);
            if (a == 0 || a == 1 || a == 2 || a == 4 || a == 5)
                model[a] <= ~din[3];
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] outs_byte();
        return {2'b00, irq_en, boot_rom_sel, 1'b0, startup_rom_sel, bus_override, aux_prom_en};
    endfunction

    // every-cycle compare against the reference (R10, R6)
    always @(negedge clk) begin
        if (model_live && !done) begin
            chk("R10 outputs vs model", outs_byte(), model);
            chk("R6 dout vs model", dout, (cs && rd_stb) ? model : 8'h00);
        end
    end

    task automatic drive(input logic c, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk); #1;
        cs = c; wr_stb = w; rd_stb = r; din = d;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic wr(input logic [7:0] d);
        drive(1'b1, 1'b1, 1'b0, d);
        idle();
    endtask

    task automatic rd_expect(input string tag, input logic [7:0] exp);
        drive(1'b1, 1'b0, 1'b1, 8'h00);
        #1 chk(tag, dout, exp);
        chk({tag, " outputs"}, outs_byte(), exp);
        idle();
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        model_live = 1'b1;
        chk("R1 reset outputs", outs_byte(), 8'h00);
        rst_n = 1'b1;
        rd_expect("R1 reset byte", 8'h00);

        // R2 R4: set each implemented position in turn
        wr(8'h00); rd_expect("R4 addr0 aux", 8'h01);
        wr(8'h01); rd_expect("R4 addr1 override", 8'h03);
        wr(8'h02); rd_expect("R4 addr2 startup", 8'h07);
        wr(8'h04); rd_expect("R4 addr4 boot", 8'h17);
        wr(8'h05); rd_expect("R2 R4 addr5 irq set", 8'h37);

        // R5: unbuilt addresses with both data values
        wr(8'h03); wr(8'h06); wr(8'h07); wr(8'h0B); wr(8'h0E); wr(8'h0F);
        rd_expect("R5 ignored addresses", 8'h37);

        // R2 R3: clearing one bit leaves the rest
        wr(8'h0D); rd_expect("R3 clear irq only", 8'h17);

        // R9: upper bits carry junk
        wr(8'hF8); rd_expect("R9 clear aux with junk", 8'h16);
        wr(8'h70); rd_expect("R9 set aux with junk", 8'h17);

        // R7: missing qualifiers
        drive(1'b0, 1'b1, 1'b0, 8'h0C); idle();
        rd_expect("R7 wr without cs", 8'h17);
        drive(1'b1, 1'b0, 1'b0, 8'h0C); idle();
        rd_expect("R7 cs without wr", 8'h17);

        // R6: repeated reads, and rd without cs
        for (int i = 0; i < 3; i++) rd_expect("R6 repeated read", 8'h17);
        drive(1'b0, 1'b0, 1'b1, 8'h00);
        #1 chk("R6 rd without cs", dout, 8'h00);
        idle();

        // R8: read and write in the same cycle (clear startup bit)
        drive(1'b1, 1'b1, 1'b1, 8'h0A);
        #1 chk("R8 same-cycle read old value", dout, 8'h17);
        idle();
        rd_expect("R8 write still lands", 8'h13);

        // R1: reset during operation
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b0;
        @(negedge clk); #1;
        rst_n = 1'b1;
        rd_expect("R1 mid-run reset", 8'h00);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule